// File: doc/BRIEF.md
# Multiplexed I/O Channel Command-Chain Engine

This block runs channel programs for a large set of slow devices on behalf of a CPU. The CPU starts work on one subchannel by giving its number and the memory address of the first command word. From then on the engine follows that subchannel's program without help. It fetches each 64-bit command word from memory. It then moves the data bytes that the word describes between memory and the device tied to that subchannel. When the program is done it queues a completion interrupt that carries the subchannel number.

Every subchannel keeps its own command pointer, current memory address, remaining byte count, direction and chain flag in a state table. One sequencer serves all of them. Each service slot handles either a command fetch or a single data byte, and a round-robin arbiter chooses the next active subchannel that has work pending. A slow device therefore never holds the engine while another device waits. Memory is a simple single port with one cycle of read latency. Each device has a byte request line and a byte acknowledge line, and all devices share one data path in each direction, selected by the engine.

Top module: `chan_engine`

## Requirements
- R1: After reset, `irq_o`, `mem_req_o` and every bit of `dev_ack_o` are low.
- R2: A start request (`sio_valid_i` high) to an inactive subchannel is accepted and makes that subchannel active. The engine then reads a command word at `sio_ptr_i`. A command word is 8 bytes little-endian: bits 7:0 op, bits 15:8 flags, bits 39:16 memory address, bits 63:40 byte count.
- R3: A start request to an active subchannel drives `sio_busy_o` high in the same cycle. The request is refused, and the running program continues as if the request had not arrived.
- R4: Op 1 moves bytes from memory to the device, taken from ascending addresses starting at the word's address, one byte per `dev_ack_o` pulse on `dev_wdata_o`. Each byte advances only that subchannel's address and count.
- R5: Op 2 stores each byte offered on `dev_rdata_i` during a `dev_ack_o` pulse to memory at ascending addresses starting at the word's address. No other location is written.
- R6: When the count of a word reaches zero, the engine acts on flags bit 0 (chain). If it is set, the engine fetches the next word at the word's own address plus 8. If it is clear, the program completes.
- R7: Op 3 (no-op) and any data word whose count is zero move no bytes. Such a word goes straight on to the chain decision of R6.
- R8: Any op other than 1, 2 or 3 ends the program at once. The engine queues a completion with `irq_err_o` set.
- R9: When several active subchannels have requests pending, they are served round-robin, one byte or fetch per slot. Two continuously requesting subchannels alternate.
- R10: Completions are kept in a FIFO of `IRQ_DEPTH` entries. `irq_o` is high while the FIFO is not empty, and `irq_sub_o`/`irq_err_o` show the oldest entry until `irq_ack_i` removes it. When the FIFO is full, the engine waits and no completion is lost.
- R11: A byte request from a subchannel that is not active is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sio_valid_i | input | 1 | Start request |
| sio_sub_i | input | SW | Subchannel to start |
| sio_ptr_i | input | 24 | Address of first command word |
| sio_busy_o | output | 1 | Start refused, subchannel active |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a byte write |
| mem_addr_o | output | 24 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 64 | Read data, the cycle after a read; byte at address in bits 7:0 |
| dev_req_i | input | NUM_SUB | Per-device byte request, held until acknowledged |
| dev_ack_o | output | NUM_SUB | Per-device byte acknowledge |
| dev_sel_o | output | SW | Device on the shared data path |
| dev_wdata_o | output | 8 | Byte to device, valid with acknowledge |
| dev_rdata_i | input | 8 | Byte from selected device |
| irq_o | output | 1 | Completion pending |
| irq_sub_o | output | SW | Subchannel of oldest completion |
| irq_err_o | output | 1 | Oldest completion ended on a bad op |
| irq_ack_i | input | 1 | Remove oldest completion |

## Verification
The bench tries the engine with the following programs:
- A chained two-word output program. This distinguishes correct chain fetch at the word's address plus 8 from a stop after the first word.
- An input program. This shows the ascending byte order and that no write strays outside the buffer.
- A no-op that chains into a one-byte word, and a zero-count word. These separate "no bytes moved" from "one stray byte moved".
- A bad op code. Only this program is expected to set the error bit.
- Two subchannels that request at the same time. Their acknowledge order tells round-robin apart from fixed priority, and their byte streams show that each keeps its own address and count.
- A busy start in the middle of a program, a request from an idle subchannel, and five completions left unread against a four-entry queue. These cover refusal, ignoring a request, and back-pressure without loss.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int CW_W   = 64;
  localparam int FLD_W  = 24;
  localparam int CHAIN_BIT = 0;

  localparam logic [7:0] OP_TO_DEV   = 8'h01;
  localparam logic [7:0] OP_FROM_DEV = 8'h02;
  localparam logic [7:0] OP_NOP      = 8'h03;

  typedef enum logic [2:0] {
    ST_ARB,
    ST_FETCH,
    ST_FETCH_DONE,
    ST_OUT_RD,
    ST_OUT_ACK,
    ST_IN
  } eng_state_e;

  typedef struct packed {
    logic             valid;
    logic             nop;
    logic             to_dev;
    logic             chain;
    logic [FLD_W-1:0] addr;
    logic [FLD_W-1:0] cnt;
  } ccw_t;
endpackage

// File: rtl/chan_ccw_decode.sv
module chan_ccw_decode
  import chan_pkg::*;
(
  input  logic [CW_W-1:0] word_i,
  output ccw_t            ccw_o
);
  logic [7:0] op;
  logic [7:0] flags;

  always_comb begin
    op           = word_i[7:0];
    flags        = word_i[15:8];
    ccw_o.valid  = (op == OP_TO_DEV) || (op == OP_FROM_DEV) || (op == OP_NOP);
    ccw_o.nop    = (op == OP_NOP);
    ccw_o.to_dev = (op == OP_TO_DEV);
    ccw_o.chain  = flags[CHAIN_BIT];
    ccw_o.addr   = word_i[39:16];
    ccw_o.cnt    = word_i[63:40];
  end
endmodule

// File: rtl/chan_rr_arb.sv
module chan_rr_arb #(
  parameter  int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;

  // search starts one past the last winner
  always_comb begin
    int j;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      j = int'(last_q) + k;
      if (j >= N) j = j - N;
      if (!gnt_valid_o && req_i[j]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IW'(N - 1);
    else if (adv_i)  last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/chan_irq_fifo.sv
module chan_irq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = slot_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) slot_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/chan_engine.sv
module chan_engine
  import chan_pkg::*;
#(
  parameter  int NUM_SUB   = 256,
  parameter  int IRQ_DEPTH = 4,
  localparam int SW        = $clog2(NUM_SUB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sio_valid_i,
  input  logic [SW-1:0]      sio_sub_i,
  input  logic [FLD_W-1:0]   sio_ptr_i,
  output logic               sio_busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [FLD_W-1:0]   mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [CW_W-1:0]    mem_rdata_i,
  input  logic [NUM_SUB-1:0] dev_req_i,
  output logic [NUM_SUB-1:0] dev_ack_o,
  output logic [SW-1:0]      dev_sel_o,
  output logic [7:0]         dev_wdata_o,
  input  logic [7:0]         dev_rdata_i,
  output logic               irq_o,
  output logic [SW-1:0]      irq_sub_o,
  output logic               irq_err_o,
  input  logic               irq_ack_i
);
  // per-subchannel state table
  logic [NUM_SUB-1:0] active_q, fetch_q, todev_q, chain_q;
  logic [FLD_W-1:0]   ptr_q  [NUM_SUB];
  logic [FLD_W-1:0]   addr_q [NUM_SUB];
  logic [FLD_W-1:0]   cnt_q  [NUM_SUB];

  eng_state_e    state_q;
  logic [SW-1:0] cur_q;
  ccw_t          ccw;

  logic [NUM_SUB-1:0] pend;
  logic               gnt_valid, adv, fifo_full, fifo_empty;
  logic [SW-1:0]      gnt_idx;
  logic               sio_take, xfer, last_byte, word_end, push, push_err;
  logic [FLD_W-1:0]   cur_cnt;
  logic               cur_chain;
  logic [SW:0]        head;

  chan_ccw_decode u_dec (
    .word_i (mem_rdata_i),
    .ccw_o  (ccw)
  );

  assign sio_busy_o = sio_valid_i && active_q[sio_sub_i];
  assign sio_take   = sio_valid_i && !active_q[sio_sub_i];

  // a non-fetching active subchannel always holds a data word
  assign pend = active_q & (fetch_q | dev_req_i);
  assign adv  = (state_q == ST_ARB) && gnt_valid && !fifo_full;

  chan_rr_arb #(.N(NUM_SUB)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (pend),
    .adv_i       (adv),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  assign cur_cnt   = cnt_q[cur_q];
  assign cur_chain = chain_q[cur_q];
  assign xfer      = (state_q == ST_OUT_ACK) || (state_q == ST_IN);
  assign last_byte = xfer && (cur_cnt == FLD_W'(1));
  assign word_end  = ccw.valid && (ccw.nop || (ccw.cnt == '0));
  assign push_err  = (state_q == ST_FETCH_DONE) && !ccw.valid;
  assign push      = push_err
                   || ((state_q == ST_FETCH_DONE) && word_end && !ccw.chain)
                   || (last_byte && !cur_chain);

  chan_irq_fifo #(.DEPTH(IRQ_DEPTH), .W(SW + 1)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({push_err, cur_q}),
    .pop_i   (irq_ack_i),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .head_o  (head)
  );

  assign irq_o     = !fifo_empty;
  assign irq_sub_o = head[SW-1:0];
  assign irq_err_o = head[SW];

  // memory and device side
  always_comb begin
    mem_req_o  = (state_q == ST_FETCH) || (state_q == ST_OUT_RD) || (state_q == ST_IN);
    mem_we_o   = (state_q == ST_IN);
    mem_addr_o = (state_q == ST_FETCH) ? ptr_q[cur_q] : addr_q[cur_q];
    dev_ack_o  = '0;
    if (xfer) dev_ack_o[cur_q] = 1'b1;
  end

  assign mem_wdata_o = dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i[7:0];
  assign dev_sel_o   = cur_q;

  // sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARB;
      cur_q   <= '0;
    end else begin
      case (state_q)
        ST_ARB: if (adv) begin
          cur_q <= gnt_idx;
          if (fetch_q[gnt_idx])      state_q <= ST_FETCH;
          else if (todev_q[gnt_idx]) state_q <= ST_OUT_RD;
          else                       state_q <= ST_IN;
        end
        ST_FETCH:   state_q <= ST_FETCH_DONE;
        ST_OUT_RD:  state_q <= ST_OUT_ACK;
        default:    state_q <= ST_ARB;
      endcase
    end
  end

  // state table update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      fetch_q  <= '0;
      todev_q  <= '0;
      chain_q  <= '0;
      for (int i = 0; i < NUM_SUB; i++) begin
        ptr_q[i]  <= '0;
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else begin
      if (state_q == ST_FETCH_DONE) begin
        ptr_q[cur_q] <= ptr_q[cur_q] + FLD_W'(8);
        if (!ccw.valid) begin
          active_q[cur_q] <= 1'b0;
        end else if (word_end) begin
          if (!ccw.chain) active_q[cur_q] <= 1'b0;
        end else begin
          fetch_q[cur_q] <= 1'b0;
          addr_q[cur_q]  <= ccw.addr;
          cnt_q[cur_q]   <= ccw.cnt;
          todev_q[cur_q] <= ccw.to_dev;
          chain_q[cur_q] <= ccw.chain;
        end
      end
      if (xfer) begin
        addr_q[cur_q] <= addr_q[cur_q] + FLD_W'(1);
        cnt_q[cur_q]  <= cur_cnt - FLD_W'(1);
        if (last_byte) begin
          if (cur_chain) fetch_q[cur_q]  <= 1'b1;
          else           active_q[cur_q] <= 1'b0;
        end
      end
      if (sio_take) begin
        active_q[sio_sub_i] <= 1'b1;
        fetch_q[sio_sub_i]  <= 1'b1;
        ptr_q[sio_sub_i]    <= sio_ptr_i;
      end
    end
  end
endmodule

// File: rtl/chan_engine_chk.sv
module chan_engine_chk #(
  parameter  int NUM_SUB = 256,
  localparam int SW      = $clog2(NUM_SUB)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sio_valid_i,
  input logic [SW-1:0]      sio_sub_i,
  input logic               sio_busy_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [NUM_SUB-1:0] dev_ack_o,
  input logic               irq_o,
  input logic [SW-1:0]      irq_sub_o,
  input logic               irq_err_o,
  input logic               irq_ack_i
);
  p_ack_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_ack_o));

  p_write_with_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && (|dev_ack_o)));

  p_out_after_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dev_ack_o) && !mem_we_o) |-> $past(mem_req_o && !mem_we_o));

  p_restart_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sio_valid_i && !sio_busy_o) |=>
      (!(sio_valid_i && (sio_sub_i == $past(sio_sub_i))) || sio_busy_o));

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> (irq_o && $stable(irq_sub_o) && $stable(irq_err_o)));
endmodule

bind chan_engine chan_engine_chk #(.NUM_SUB(NUM_SUB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sio_valid_i (sio_valid_i),
  .sio_sub_i   (sio_sub_i),
  .sio_busy_o  (sio_busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .dev_ack_o   (dev_ack_o),
  .irq_o       (irq_o),
  .irq_sub_o   (irq_sub_o),
  .irq_err_o   (irq_err_o),
  .irq_ack_i   (irq_ack_i)
);

// File: tb/chan_engine_bench.sv
`timescale 1ns/1ps
module chan_engine_bench;
  localparam int NS = 256;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sio_valid_i = 1'b0;
  logic [7:0]    sio_sub_i = '0;
  logic [23:0]   sio_ptr_i = '0;
  logic          sio_busy_o;
  logic          mem_req_o, mem_we_o;
  logic [23:0]   mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic [63:0]   mem_rdata_i = '0;
  logic [NS-1:0] dev_req_i = '0;
  logic [NS-1:0] dev_ack_o;
  logic [7:0]    dev_sel_o, dev_wdata_o, dev_rdata_i;
  logic          irq_o, irq_err_o;
  logic [7:0]    irq_sub_o;
  logic          irq_ack_i = 1'b0;

  always #2.5 clk = ~clk;

  chan_engine u_chan_engine (
    .clk_i(clk), .rst_ni(rst_ni),
    .sio_valid_i(sio_valid_i), .sio_sub_i(sio_sub_i), .sio_ptr_i(sio_ptr_i),
    .sio_busy_o(sio_busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .dev_req_i(dev_req_i), .dev_ack_o(dev_ack_o), .dev_sel_o(dev_sel_o),
    .dev_wdata_o(dev_wdata_o), .dev_rdata_i(dev_rdata_i),
    .irq_o(irq_o), .irq_sub_o(irq_sub_o), .irq_err_o(irq_err_o), .irq_ack_i(irq_ack_i)
  );

  // behavioural memory and device models
  logic [7:0] mem [4096];
  int         want [NS];
  int         ack_total [NS];
  logic [7:0] got [NS][16];
  int         got_n [NS];
  logic [7:0] in_base [NS];
  logic [7:0] in_idx [NS];
  int         ack_seq [64];
  int         n_seq;
  int         n_cmp, n_bad;

  assign dev_rdata_i = in_base[dev_sel_o] + in_idx[dev_sel_o];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_o) begin
        if (mem_we_o) mem[mem_addr_o[11:0]] = mem_wdata_o;
        else
          for (int b = 0; b < 8; b++)
            mem_rdata_i[b*8 +: 8] = mem[(mem_addr_o[11:0] + 12'(b))];
      end
      for (int i = 0; i < NS; i++) begin
        if (dev_ack_o[i]) begin
          ack_total[i]++;
          if (n_seq < 64) begin ack_seq[n_seq] = i; n_seq++; end
          if (want[i] > 0) want[i]--;
          if (got_n[i] < 16) begin got[i][got_n[i]] = dev_wdata_o; got_n[i]++; end
          in_idx[i] = in_idx[i] + 8'd1;
        end
      end
      for (int i = 0; i < NS; i++) dev_req_i[i] = (want[i] > 0);
    end
  end

  task automatic put_ccw(input int ptr, input logic [7:0] op, input logic [7:0] flg,
                         input logic [23:0] addr, input logic [23:0] cnt);
    logic [63:0] w;
    w = {cnt, addr, flg, op};
    for (int b = 0; b < 8; b++) mem[ptr + b] = w[b*8 +: 8];
  endtask

  task automatic start_io(input int sub, input int ptr, input bit exp_busy, input string req);
    @(negedge clk);
    sio_valid_i = 1'b1; sio_sub_i = 8'(sub); sio_ptr_i = 24'(ptr);
    #1;
    check(sio_busy_o == exp_busy, req, "start busy response", sio_busy_o, exp_busy);
    @(negedge clk);
    sio_valid_i = 1'b0;
  endtask

  task automatic take_irq(output int sub, output int err);
    int t;
    t = 0;
    while (!irq_o && t < 3000) begin @(negedge clk); t++; end
    if (!irq_o) begin sub = -1; err = -1; end
    else begin
      sub = irq_sub_o; err = irq_err_o;
      irq_ack_i = 1'b1;
      @(negedge clk);
      irq_ack_i = 1'b0;
    end
  endtask

  task automatic expect_irq(input int sub, input int err, input string req);
    int s, e;
    take_irq(s, e);
    check(s == sub, req, "irq subchannel", s, sub);
    check(e == err, req, "irq error bit", e, err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seen [5];
    int s, e;
    bit alt;
    n_cmp = 0; n_bad = 0; n_seq = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    for (int i = 0; i < NS; i++) begin
      want[i] = 0; ack_total[i] = 0; got_n[i] = 0; in_base[i] = 8'h00; in_idx[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R1", "irq after reset", irq_o, 0);
    check(mem_req_o == 1'b0, "R1", "mem_req after reset", mem_req_o, 0);
    check(dev_ack_o == '0, "R1", "dev_ack after reset", 1, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R6: chained output program on subchannel 5, busy restart (R3)
    put_ccw(12'h100, 8'h01, 8'h01, 24'h400, 24'd3);
    put_ccw(12'h108, 8'h01, 8'h00, 24'h500, 24'd2);
    put_ccw(12'h200, 8'h44, 8'h00, 24'h000, 24'd0);
    mem[12'h400] = 8'h11; mem[12'h401] = 8'h22; mem[12'h402] = 8'h33;
    mem[12'h500] = 8'h44; mem[12'h501] = 8'h55;
    want[5] = 5;
    start_io(5, 12'h100, 1'b0, "R2");
    start_io(5, 12'h200, 1'b1, "R3");
    expect_irq(5, 0, "R6");
    check(got_n[5] == 5, "R6", "bytes through chain", got_n[5], 5);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] ex;
      ex = 8'h11 * 8'(k + 1);
      check(got[5][k] == ex, "R4", "out byte", got[5][k], ex);
    end

    // R5: input program on subchannel 7
    in_base[7] = 8'hA0;
    put_ccw(12'h140, 8'h02, 8'h00, 24'h600, 24'd4);
    want[7] = 4;
    start_io(7, 12'h140, 1'b0, "R2");
    expect_irq(7, 0, "R5");
    for (int k = 0; k < 4; k++)
      check(mem[12'h600 + k] == 8'hA0 + 8'(k), "R5", "stored byte", mem[12'h600 + k], 8'hA0 + k);
    check(mem[12'h604] == 8'h00, "R5", "byte past buffer", mem[12'h604], 0);

    // R7: no-op chaining to one byte, and zero-count word
    put_ccw(12'h180, 8'h03, 8'h01, 24'h000, 24'd9);
    put_ccw(12'h188, 8'h01, 8'h00, 24'h480, 24'd1);
    mem[12'h480] = 8'h5A;
    want[9] = 3;
    start_io(9, 12'h180, 1'b0, "R7");
    expect_irq(9, 0, "R7");
    check(ack_total[9] == 1, "R7", "bytes for nop+1", ack_total[9], 1);
    check(got[9][0] == 8'h5A, "R7", "byte after nop", got[9][0], 8'h5A);
    want[9] = 0;
    put_ccw(12'h1C0, 8'h02, 8'h00, 24'h680, 24'd0);
    start_io(11, 12'h1C0, 1'b0, "R7");
    expect_irq(11, 0, "R7");
    check(ack_total[11] == 0, "R7", "bytes for zero count", ack_total[11], 0);

    // R8: bad op
    put_ccw(12'h1E0, 8'h44, 8'h01, 24'h000, 24'd5);
    start_io(12, 12'h1E0, 1'b0, "R8");
    expect_irq(12, 1, "R8");

    // R9: two subchannels requesting together alternate
    put_ccw(12'h220, 8'h01, 8'h00, 24'h700, 24'd4);
    put_ccw(12'h228, 8'h01, 8'h00, 24'h780, 24'd4);
    for (int k = 0; k < 4; k++) begin
      mem[12'h700 + k] = 8'h70 + 8'(k);
      mem[12'h780 + k] = 8'h90 + 8'(k);
    end
    start_io(1, 12'h220, 1'b0, "R9");
    start_io(2, 12'h228, 1'b0, "R9");
    repeat (20) @(negedge clk);
    n_seq = 0;
    want[1] = 4; want[2] = 4;
    expect_irq(1, 0, "R9");
    expect_irq(2, 0, "R9");
    check(n_seq == 8, "R9", "acks served", n_seq, 8);
    alt = 1'b1;
    for (int k = 0; k < 7; k++) if (ack_seq[k] == ack_seq[k+1]) alt = 1'b0;
    check(alt, "R9", "alternating service", alt, 1);
    for (int k = 0; k < 4; k++) begin
      check(got[1][k] == 8'h70 + 8'(k), "R4", "sub1 own stream", got[1][k], 8'h70 + k);
      check(got[2][k] == 8'h90 + 8'(k), "R4", "sub2 own stream", got[2][k], 8'h90 + k);
    end

    // R11: idle subchannel request ignored
    want[20] = 1;
    repeat (30) @(negedge clk);
    check(ack_total[20] == 0, "R11", "ack to idle subchannel", ack_total[20], 0);
    want[20] = 0;
    @(negedge clk);

    // R10: five completions against a four-entry queue
    for (int k = 0; k < 5; k++) begin
      put_ccw(12'h300 + 8*k, 8'h03, 8'h00, 24'h0, 24'd0);
      start_io(30 + k, 12'h300 + 8*k, 1'b0, "R10");
    end
    repeat (80) @(negedge clk);
    check(irq_o == 1'b1, "R10", "irq pending", irq_o, 1);
    for (int k = 0; k < 5; k++) seen[k] = 0;
    for (int k = 0; k < 5; k++) begin
      take_irq(s, e);
      check(s >= 30 && s <= 34, "R10", "queued subchannel", s, 30 + k);
      check(e == 0, "R10", "queued error bit", e, 0);
      if (s >= 30 && s <= 34) seen[s-30]++;
    end
    for (int k = 0; k < 5; k++)
      check(seen[k] == 1, "R10", "completion kept once", seen[k], 1);
    @(negedge clk);
    check(irq_o == 1'b0, "R10", "queue drained", irq_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule